// File: doc/BRIEF.md
# Passive Parallel Configuration Host Controller

This block acts as the external host that loads an FPGA over an 8-bit passive parallel configuration port. It serves the case where the bitstream is compressed or encrypted, so every byte must stay on the data lines for several configuration-clock rising edges. A start request runs the whole sequence. The block pulses the target's program-request line low, waits for the target's status line to go low and then return high, and lets a settle time pass. It then clocks the byte stream from a valid/ready source onto the data lines, one byte per group of edges.

The configuration clock is produced by dividing the system clock. Data changes only while the configuration clock is low. When the source runs dry, the clock parks low and the held byte stays on the lines. When the target signals that it has accepted the bitstream, the host sends a fixed number of extra clock pulses. It then waits for the target's initialisation flag, or for a timeout, and reports done. If the target pulls its status line low during the load, clocking stops and an error is flagged. A new start request then retries from the program pulse. All target inputs pass through a synchroniser, and the configuration clock is always driven, never left floating.

Top module: `pp_cfg_host`

## Requirements
- R1: After reset, prog_no is 1, dclk_o is 0, dq_o is 0x00, and byte_ready_o, done_o and err_o are 0.
- R2: A start_i pulse taken in idle, done or error drives prog_no low for exactly PULSE_CYC system clock cycles.
- R3: No dclk_o rising edge occurs until tgt_stat_ni has been seen low and then high again. The first rising edge comes at least WAIT_CYC cycles after tgt_stat_ni goes high.
- R4: Each accepted byte is presented on dq_o for exactly EDGES_PER_BYTE (4) dclk_o rising edges. dq_o does not change while dclk_o is high.
- R5: While clocking, each high phase of dclk_o lasts exactly DIV cycles and each low phase lasts at least DIV cycles.
- R6: While no byte is offered, dclk_o stays low and the byte last presented stays on dq_o. A newly loaded byte is stable on dq_o for at least DIV cycles before the next rising edge.
- R7: byte_ready_o is high only during the load phase, only while dclk_o is low, and only after the fourth edge of the previous byte. Each handshake takes exactly one byte, and bytes reach dq_o in the order given.
- R8: After tgt_cdone_i rises, exactly EXTRA_CLKS further dclk_o rising edges are sent. No further byte is accepted, and dclk_o then stays low.
- R9: After the extra edges, done_o rises a few cycles after tgt_init_i goes high. If tgt_init_i never rises, done_o rises INIT_TO cycles after the last dclk_o falling edge.
- R10: If tgt_stat_ni goes low during settle, load or extra clocking, dclk_o stops within a few cycles, err_o goes high and byte_ready_o stays low. A later start_i retries the whole sequence.
- R11: While done_o is high, dclk_o is driven low, prog_no is high, and byte_ready_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin (or retry) a configuration cycle |
| byte_valid_i | input | 1 | Source has a bitstream byte |
| byte_data_i | input | 8 | Bitstream byte |
| byte_ready_o | output | 1 | Host takes byte_data_i this cycle if valid |
| prog_no | output | 1 | Active-low program request to target |
| dclk_o | output | 1 | Configuration clock, always driven |
| dq_o | output | 8 | Configuration data lines |
| tgt_stat_ni | input | 1 | Target status, low while resetting or on error |
| tgt_cdone_i | input | 1 | Target reports bitstream accepted |
| tgt_init_i | input | 1 | Target reports initialisation complete |
| done_o | output | 1 | Configuration finished |
| err_o | output | 1 | Target reported an error during load |

## Verification
Two events can fall in the same cycle window. One is the target's completion flag arriving. The other is the host finishing the fourth edge of the last byte, since the flag lands while that byte's final high phase is still running and its falling edge is taken inside the extra-clock phase. The bench model raises the flag on exactly that rising edge and requires exactly EXTRA_CLKS rising edges afterwards, with byte_ready_o never high again. The error path is provoked the same way: the status line is pulled low on the edge that completes a byte, and the bench requires that no ready pulse and no further edge follows.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SETTLE,
    ST_XFER,
    ST_EXTRA,
    ST_INIT,
    ST_DONE,
    ST_ERR
  } cfg_st_e;
endpackage

// File: rtl/ppcfg_sync.sv
module ppcfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppcfg_dclk_gen.sv
module ppcfg_dclk_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic dclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt_q;
  logic          dclk_q;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  // one-cycle lookahead strobes
  assign rise_o = !clear_i && !dclk_q && run_i && last;
  assign fall_o = !clear_i && dclk_q && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      dclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (dclk_q) begin
      // a started high phase always completes
      if (last) begin
        dclk_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (run_i) begin
      if (last) begin
        dclk_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign dclk_o = dclk_q;

  a_r5_rise_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_q) |-> $past(run_i));
endmodule

// File: rtl/ppcfg_seq.sv
module ppcfg_seq
  import ppcfg_pkg::*;
#(
  parameter int unsigned PULSE_CYC      = 8,
  parameter int unsigned WAIT_CYC       = 4,
  parameter int unsigned EDGES_PER_BYTE = 4,
  parameter int unsigned EXTRA_CLKS     = 4,
  parameter int unsigned INIT_TO        = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_data_i,
  input  logic       stat_i,
  input  logic       cdone_i,
  input  logic       init_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       dclk_i,
  output logic       run_o,
  output logic       clear_o,
  output logic       byte_ready_o,
  output logic [7:0] data_o,
  output logic       prog_no,
  output logic       done_o,
  output logic       err_o
);
  localparam int unsigned TMAX0 = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
  localparam int unsigned TMAX  = (TMAX0 > INIT_TO) ? TMAX0 : INIT_TO;
  localparam int unsigned TW    = $clog2(TMAX + 1);
  localparam int unsigned KW    = $clog2(EDGES_PER_BYTE + 1);
  localparam int unsigned XW    = $clog2(EXTRA_CLKS + 2);

  cfg_st_e       st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic [KW-1:0] kcnt_q;
  logic [XW-1:0] xcnt_q;
  logic [7:0]    data_q;
  logic          have_q;
  logic          seen_lo_q;
  logic          load;
  logic          last_edge;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start_i) st_d = ST_PULSE;
      ST_PULSE:  if (tmr_q == TW'(PULSE_CYC - 1)) st_d = ST_WAIT;
      ST_WAIT:   if (stat_i && seen_lo_q) st_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!stat_i) st_d = ST_ERR;
        else if (tmr_q == TW'(WAIT_CYC - 1)) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (!stat_i) st_d = ST_ERR;
        else if (cdone_i) st_d = (EXTRA_CLKS == 0) ? ST_INIT : ST_EXTRA;
      end
      ST_EXTRA: begin
        if (!stat_i) st_d = ST_ERR;
        else if (fall_i && xcnt_q == XW'(EXTRA_CLKS)) st_d = ST_INIT;
      end
      ST_INIT: if (init_i || tmr_q == TW'(INIT_TO - 1)) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)       tmr_q <= '0;
      else if (tmr_q != TW'(TMAX)) tmr_q <= tmr_q + 1'b1;
    end
  end

  // status must be observed low before its release is trusted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_lo_q <= 1'b0;
    else if (st_q != ST_PULSE && st_d == ST_PULSE) seen_lo_q <= 1'b0;
    else if ((st_q == ST_PULSE || st_q == ST_WAIT) && !stat_i) seen_lo_q <= 1'b1;
  end

  assign byte_ready_o = (st_q == ST_XFER) && !have_q;
  assign load         = byte_ready_o && byte_valid_i;
  assign last_edge    = (kcnt_q == KW'(EDGES_PER_BYTE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      have_q <= 1'b0;
      kcnt_q <= '0;
    end else if (st_q != ST_XFER) begin
      have_q <= 1'b0;
      kcnt_q <= '0;
    end else if (load) begin
      data_q <= byte_data_i;
      have_q <= 1'b1;
      kcnt_q <= '0;
    end else if (have_q && fall_i) begin
      if (last_edge) begin
        have_q <= 1'b0;
        kcnt_q <= '0;
      end else begin
        kcnt_q <= kcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                xcnt_q <= '0;
    else if (st_q != ST_EXTRA)  xcnt_q <= '0;
    else if (rise_i)            xcnt_q <= xcnt_q + 1'b1;
  end

  assign run_o   = ((st_q == ST_XFER) && have_q) || (st_q == ST_EXTRA);
  assign clear_o = !((st_q == ST_XFER) || (st_q == ST_EXTRA));
  assign data_o  = data_q;
  assign prog_no = (st_q != ST_PULSE);
  assign done_o  = (st_q == ST_DONE);
  assign err_o   = (st_q == ST_ERR);

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_i |-> $stable(data_q));
  a_r7_ready_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !dclk_i);
  a_r7_one_per_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && byte_valid_i) |=> !byte_ready_o);
  a_r10_err_stops_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !dclk_i);
  a_r2_no_clk_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !dclk_i);
  a_r11_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!dclk_i && !byte_ready_o));
endmodule

// File: rtl/pp_cfg_host.sv
module pp_cfg_host #(
  parameter int unsigned PULSE_CYC      = 8,
  parameter int unsigned WAIT_CYC       = 4,
  parameter int unsigned DIV            = 4,
  parameter int unsigned EDGES_PER_BYTE = 4,
  parameter int unsigned EXTRA_CLKS     = 4,
  parameter int unsigned INIT_TO        = 64,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_data_i,
  output logic       byte_ready_o,
  output logic       prog_no,
  output logic       dclk_o,
  output logic [7:0] dq_o,
  input  logic       tgt_stat_ni,
  input  logic       tgt_cdone_i,
  input  logic       tgt_init_i,
  output logic       done_o,
  output logic       err_o
);
  logic [2:0] tgt_raw, tgt_s;
  logic       run, clear, rise, fall, dclk;

  assign tgt_raw = {tgt_init_i, tgt_cdone_i, tgt_stat_ni};

  ppcfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgt_raw),
    .q_o   (tgt_s)
  );

  ppcfg_dclk_gen #(.DIV(DIV)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clear_i(clear),
    .dclk_o (dclk),
    .rise_o (rise),
    .fall_o (fall)
  );

  ppcfg_seq #(
    .PULSE_CYC     (PULSE_CYC),
    .WAIT_CYC      (WAIT_CYC),
    .EDGES_PER_BYTE(EDGES_PER_BYTE),
    .EXTRA_CLKS    (EXTRA_CLKS),
    .INIT_TO       (INIT_TO)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .byte_valid_i(byte_valid_i),
    .byte_data_i (byte_data_i),
    .stat_i      (tgt_s[0]),
    .cdone_i     (tgt_s[1]),
    .init_i      (tgt_s[2]),
    .rise_i      (rise),
    .fall_i      (fall),
    .dclk_i      (dclk),
    .run_o       (run),
    .clear_o     (clear),
    .byte_ready_o(byte_ready_o),
    .data_o      (dq_o),
    .prog_no     (prog_no),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign dclk_o = dclk;
endmodule

// File: tb/tb_pp_cfg_host.sv
`timescale 1ns/1ps
module tb_pp_cfg_host;
  localparam int PULSE_CYC = 8;
  localparam int WAIT_CYC  = 4;
  localparam int DIV       = 4;
  localparam int EDGES     = 4;
  localparam int EXTRA     = 4;
  localparam int INIT_TO   = 64;
  localparam int STAT_DLY  = 12;
  localparam int INIT_DLY  = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bvalid = 1'b0;
  logic [7:0] bdata = 8'h00;
  logic       tgt_stat = 1'b0;
  logic       tgt_cdone = 1'b0;
  logic       tgt_init = 1'b0;
  logic       byte_ready_o, prog_no, dclk_o, done_o, err_o;
  logic [7:0] dq_o;

  always #2.5 clk = ~clk;

  pp_cfg_host #(
    .PULSE_CYC(PULSE_CYC), .WAIT_CYC(WAIT_CYC), .DIV(DIV),
    .EDGES_PER_BYTE(EDGES), .EXTRA_CLKS(EXTRA), .INIT_TO(INIT_TO), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .byte_valid_i(bvalid), .byte_data_i(bdata), .byte_ready_o(byte_ready_o),
    .prog_no(prog_no), .dclk_o(dclk_o), .dq_o(dq_o),
    .tgt_stat_ni(tgt_stat), .tgt_cdone_i(tgt_cdone), .tgt_init_i(tgt_init),
    .done_o(done_o), .err_o(err_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_mem [0:63];
  int n_cfg = 0, err_at = 0;
  bit init_never = 0;

  // monitor / target model state
  logic dclk_prev = 1'b0, cfg_prev = 1'b1;
  logic [7:0] data_prev = 8'h00, grp_data = 8'h00;
  int hi_len = 0, lo_len = 0, cfg_lo_len = 0, grp = 0, byte_idx = 0, post_rises = 0;
  int data_age = 0, since_stat = 0, stat_lo_len = 0, stat_cd = 20, init_cd = -1;
  int rises_total = 0, last_fall_cyc = 0, init_set_cyc = 0;
  bit first_rise_seen = 0;

  function automatic int exp_total_rises(int nb);
    return nb * EDGES + EXTRA;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (!prog_no) begin
      if (cfg_prev) cfg_lo_len = 0;
      cfg_lo_len++;
      tgt_stat = 1'b0; tgt_cdone = 1'b0; tgt_init = 1'b0;
      stat_cd = -1; init_cd = -1; grp = 0; byte_idx = 0; post_rises = 0;
      first_rise_seen = 0;
    end else if (!cfg_prev) begin
      chk(cfg_lo_len == PULSE_CYC, "R2 pulse width", cfg_lo_len, PULSE_CYC);
      stat_cd = STAT_DLY;
    end
    if (stat_cd > 0) stat_cd--;
    else if (stat_cd == 0) begin tgt_stat = 1'b1; stat_cd = -1; since_stat = 0; end
    since_stat++;
    stat_lo_len = tgt_stat ? 0 : stat_lo_len + 1;
    if (dq_o != data_prev) data_age = 0; else data_age++;

    if (dclk_o && !dclk_prev) begin
      rises_total++;
      hi_len = 1;
      chk(stat_lo_len < 5, "R10 edge while status low", stat_lo_len, 0);
      if (!first_rise_seen) begin
        first_rise_seen = 1;
        chk(since_stat >= WAIT_CYC, "R3 first edge delay", since_stat, WAIT_CYC);
      end else begin
        chk(lo_len >= DIV, "R5 low width", lo_len, DIV);
      end
      if (tgt_cdone) post_rises++;
      else begin
        if (grp == 0) begin
          chk(data_age >= DIV, "R6 data setup", data_age, DIV);
          grp_data = dq_o;
        end else begin
          chk(dq_o == grp_data, "R4 data stable in byte", dq_o, grp_data);
        end
        grp++;
        if (grp == EDGES) begin
          chk(grp_data == exp_mem[byte_idx], "R7 byte order", grp_data, exp_mem[byte_idx]);
          byte_idx++;
          grp = 0;
          if (byte_idx == n_cfg) begin
            tgt_cdone = 1'b1;
            init_cd = init_never ? -1 : INIT_DLY;
          end
          if (byte_idx == err_at) tgt_stat = 1'b0;
        end
      end
    end else if (dclk_o) begin
      hi_len++;
    end else if (dclk_prev) begin
      chk(hi_len == DIV, "R5 high width", hi_len, DIV);
      lo_len = 1;
      last_fall_cyc = cyc;
    end else begin
      lo_len++;
    end

    if (byte_ready_o)
      chk(grp == 0 && !tgt_cdone && !dclk_o, "R7/R8 ready window", grp, 0);

    if (init_cd > 0) init_cd--;
    else if (init_cd == 0) begin tgt_init = 1'b1; init_set_cyc = cyc; init_cd = -1; end

    dclk_prev = dclk_o; cfg_prev = prog_no; data_prev = dq_o;
  end

  task automatic feed(int nb, int pause_at);
    bit abort = 0;
    for (int i = 0; i < nb; i++) begin
      bvalid = 1'b1;
      bdata  = exp_mem[i];
      forever begin
        @(negedge clk);
        if (err_o) begin abort = 1; break; end
        if (byte_ready_o) begin @(posedge clk); #1; break; end
      end
      bvalid = 1'b0;
      if (abort) break;
      if (i == pause_at) begin
        int r0;
        repeat (40) @(negedge clk);
        r0 = rises_total;
        repeat (30) @(negedge clk);
        chk(rises_total == r0 && !dclk_o && dq_o == exp_mem[i], "R6 paused clock", rises_total, r0);
        @(posedge clk); #1;
      end else begin
        repeat ($urandom_range(0, 3)) @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic run_cfg(int nb, int pause_at, int err_i, bit never);
    int start_rises;
    n_cfg = nb; err_at = err_i; init_never = never;
    for (int i = 0; i < nb; i++) exp_mem[i] = 8'($urandom);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    start_rises = rises_total;
    fork
      feed(nb, pause_at);
      begin
        for (int w = 0; w < 20000; w++) begin
          @(negedge clk);
          if (done_o || err_o) break;
        end
      end
    join
    if (err_i > 0) begin
      int r0;
      chk(err_o && !done_o, "R10 error flag", err_o, 1);
      r0 = rises_total;
      repeat (30) begin
        @(negedge clk);
        chk(!dclk_o && !byte_ready_o && err_o, "R10 stopped after error", dclk_o, 0);
      end
      chk(rises_total == r0, "R10 no edges after error", rises_total, r0);
    end else begin
      chk(done_o, "R9 done reached", done_o, 1);
      chk(post_rises == EXTRA, "R8 extra edges", post_rises, EXTRA);
      chk(byte_idx == nb, "R7 all bytes", byte_idx, nb);
      chk(rises_total - start_rises == exp_total_rises(nb), "R4 total edges",
          rises_total - start_rises, exp_total_rises(nb));
      if (never)
        chk(cyc - last_fall_cyc >= INIT_TO - 1 && cyc - last_fall_cyc <= INIT_TO + 1,
            "R9 init timeout", cyc - last_fall_cyc, INIT_TO);
      else
        chk(cyc - init_set_cyc >= 2 && cyc - init_set_cyc <= 4,
            "R9 init response", cyc - init_set_cyc, 3);
      repeat (30) begin
        @(negedge clk);
        chk(!dclk_o && prog_no && done_o && !byte_ready_o, "R11 quiet after done", dclk_o, 0);
      end
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h0C0F_FEE5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(prog_no == 1'b1, "R1 prog_no reset", prog_no, 1);
    chk(dclk_o == 1'b0 && dq_o == 8'h00, "R1 dclk/data reset", dq_o, 0);
    chk(!byte_ready_o && !done_o && !err_o, "R1 flags reset", byte_ready_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (30) @(posedge clk);
    run_cfg(6, 2, 0, 0);
    run_cfg(24, -1, 0, 1);
    run_cfg(10, -1, 4, 0);
    run_cfg(8, 5, 0, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule